// File: doc/BRIEF.md
# Random TLB Replacement Index Generator

This block supplies the slot number that a random-replacement TLB write uses. Each request produces one index that falls inside the replaceable part of the TLB. The lower part of the table, below a boundary called the wired count, is protected and is never chosen. A 32-bit linear congruential generator provides the randomness. Its upper sixteen bits are reduced modulo the size of the replaceable window and then offset by the wired count.

The block never hands out the same index twice in a row while the window holds two or more entries. When a draw lands on the index it issued last, it advances the generator and draws again, one generator step per attempt, until the index differs. When the window holds a single entry, the block answers at once with the top slot and leaves the generator alone. A request is accepted only while the block is idle. The result comes with a one-cycle valid strobe, so a request takes a variable number of cycles.

Top module: `tlb_rand_index`

## Requirements
- R1: After reset, valid_o is 0, index_o is 0, the generator state is 1 and the last issued index is 0. Together these fix the whole later index sequence.
- R2: Each draw first advances the generator state s to (s * 1103515245 + 12345) mod 2^32. The draw then uses the new state.
- R3: With window size n = entries_i - wired_i (entries_i and wired_i are 7-bit unsigned, index_o is 6-bit unsigned), a draw yields (s >> 16) mod n + wired_i. The result always lies in [wired_i, entries_i - 1].
- R4: A draw equal to the last issued index is discarded and a fresh draw is made, until one differs. Two consecutive multi-entry results therefore never match.
- R5: When wired_i + 1 >= entries_i, the result is entries_i - 1 (truncated to 6 bits). It appears with valid_o on the cycle right after the accepting edge, and the generator state does not change.
- R6: Every issued index, from either path, becomes the last issued index that R4 compares against.
- R7: valid_o is high for one cycle per accepted request. index_o holds the last issued index while valid_o is low.
- R8: A request that arrives while a result is still being computed is ignored. It produces no result and does not advance the generator.
- R9: entries_i and wired_i are captured when a request is accepted. Changing them during the computation has no effect on that result.
- R10: The bit-serial remainder variant (SEQ_REM = 1) and the single-step variant (SEQ_REM = 0) produce the same index sequence. They differ only in latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, accepted only when idle |
| entries_i | input | $clog2(MAX_ENTRIES+1) | Total number of TLB entries |
| wired_i | input | $clog2(MAX_ENTRIES+1) | Number of protected entries at the bottom of the TLB |
| index_o | output | $clog2(MAX_ENTRIES) | Last issued replacement index |
| valid_o | output | 1 | One-cycle strobe marking a new index |

## Verification
The bench builds two copies with MAX_ENTRIES = 64. One uses SEQ_REM = 1, with a sixteen-step remainder unit. The other uses SEQ_REM = 0, with a remainder that settles in one cycle. Both are fed identical requests and checked against one expected sequence, which exercises R10 and two very different latencies.

A 64-entry table allows a full-width window (wired 0) and a single top slot (wired 63). Two-entry windows at several offsets force frequent retries. The bench also covers a wired count that equals the entry count.

// File: rtl/tlb_rand_pkg.sv
package tlb_rand_pkg;

   // generator recurrence, arithmetic modulo 2^32
   localparam int unsigned GEN_W        = 32;
   localparam logic [31:0] GEN_MUL      = 32'd1103515245;
   localparam logic [31:0] GEN_ADD      = 32'd12345;
   localparam logic [31:0] GEN_INIT     = 32'd1;
   // number of low state bits dropped before the reduction
   localparam int unsigned GEN_DROP     = 16;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_WAIT = 2'd2
   } ctl_state_e;

endpackage

// File: rtl/tlb_rand_lcg.sv
module tlb_rand_lcg #(
   parameter int unsigned            STATE_W = 32,
   parameter logic [STATE_W-1:0]     MUL     = '0,
   parameter logic [STATE_W-1:0]     ADD     = '0,
   parameter logic [STATE_W-1:0]     INIT    = '0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               step_i,
   output logic [STATE_W-1:0] state_o
);

   logic [STATE_W-1:0] state_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= INIT;
      end else if (step_i) begin
         state_q <= state_q * MUL + ADD;
      end
   end

   assign state_o = state_q;

endmodule

// File: rtl/tlb_rand_rem.sv
module tlb_rand_rem #(
   parameter int unsigned DVD_W      = 16,
   parameter int unsigned DVS_W      = 7,
   parameter bit          SEQUENTIAL = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic [DVD_W-1:0] dividend_i,
   input  logic [DVS_W-1:0] divisor_i,
   output logic             done_o,
   output logic [DVS_W-1:0] rem_o
);

   localparam int unsigned CNT_W = $clog2(DVD_W + 1);

   if (DVS_W >= DVD_W) begin : g_bad_width
      $error("tlb_rand_rem: divisor must be narrower than dividend");
   end

   if (SEQUENTIAL) begin : g_serial
      // restoring remainder, one dividend bit per cycle
      logic [DVS_W-1:0] part_q;
      logic [DVD_W-1:0] shf_q;
      logic [DVS_W-1:0] dvs_q;
      logic [CNT_W-1:0] cnt_q;
      logic             run_q;
      logic             done_q;
      logic [DVS_W:0]   trial_w;
      logic [DVS_W:0]   diff_w;

      assign trial_w = {part_q, shf_q[DVD_W-1]};
      assign diff_w  = trial_w - {1'b0, dvs_q};

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            part_q <= '0;
            shf_q  <= '0;
            dvs_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
         end else begin
            done_q <= 1'b0;
            if (start_i) begin
               part_q <= '0;
               shf_q  <= dividend_i;
               dvs_q  <= divisor_i;
               cnt_q  <= CNT_W'(DVD_W);
               run_q  <= 1'b1;
            end else if (run_q) begin
               if (trial_w >= {1'b0, dvs_q}) begin
                  part_q <= diff_w[DVS_W-1:0];
               end else begin
                  part_q <= trial_w[DVS_W-1:0];
               end
               shf_q <= {shf_q[DVD_W-2:0], 1'b0};
               cnt_q <= cnt_q - CNT_W'(1);
               if (cnt_q == CNT_W'(1)) begin
                  run_q  <= 1'b0;
                  done_q <= 1'b1;
               end
            end
         end
      end

      assign done_o = done_q;
      assign rem_o  = part_q;
   end else begin : g_single
      // full remainder in one cycle, result registered
      logic [DVD_W-1:0] full_w;
      logic [DVS_W-1:0] rem_q;
      logic             done_q;

      assign full_w = (divisor_i == '0) ? '0 : (dividend_i % DVD_W'(divisor_i));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            rem_q  <= '0;
            done_q <= 1'b0;
         end else begin
            done_q <= start_i;
            if (start_i) begin
               rem_q <= full_w[DVS_W-1:0];
            end
         end
      end

      assign done_o = done_q;
      assign rem_o  = rem_q;
   end

endmodule

// File: rtl/tlb_rand_index.sv
module tlb_rand_index
   import tlb_rand_pkg::*;
#(
   parameter int unsigned MAX_ENTRIES = 64,
   parameter bit          SEQ_REM     = 1'b1
) (
   input  logic                                 clk_i,
   input  logic                                 rst_ni,
   input  logic                                 req_i,
   input  logic [$clog2(MAX_ENTRIES+1)-1:0]     entries_i,
   input  logic [$clog2(MAX_ENTRIES+1)-1:0]     wired_i,
   output logic [$clog2(MAX_ENTRIES)-1:0]       index_o,
   output logic                                 valid_o
);

   localparam int unsigned IDX_W = $clog2(MAX_ENTRIES);
   localparam int unsigned CNT_W = $clog2(MAX_ENTRIES + 1);
   localparam int unsigned KEY_W = GEN_W - GEN_DROP;

   if (MAX_ENTRIES < 2) begin : g_bad_size
      $error("tlb_rand_index: MAX_ENTRIES must be at least 2");
   end
   if (CNT_W >= KEY_W) begin : g_bad_key
      $error("tlb_rand_index: MAX_ENTRIES too large for the generator key");
   end

   ctl_state_e           state_q, state_d;
   logic                 busy_w;
   logic                 single_w;
   logic                 lcg_step;
   logic                 rem_start;
   logic                 rem_done;
   logic [CNT_W-1:0]     rem_w;
   logic [GEN_W-1:0]     seed_w;
   logic [CNT_W-1:0]     wir_q;
   logic [CNT_W-1:0]     span_q;
   logic [IDX_W-1:0]     last_q;
   logic                 valid_q;
   logic [IDX_W-1:0]     cand_w;
   logic                 unused_low;

   assign busy_w     = (state_q != ST_IDLE);
   assign single_w   = ({1'b0, wired_i} + (CNT_W+1)'(1)) >= {1'b0, entries_i};
   assign cand_w     = IDX_W'(rem_w + wir_q);
   assign unused_low = ^seed_w[GEN_DROP-1:0];

   tlb_rand_lcg #(
      .STATE_W (GEN_W),
      .MUL     (GEN_MUL),
      .ADD     (GEN_ADD),
      .INIT    (GEN_INIT)
   ) u_gen (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .step_i  (lcg_step),
      .state_o (seed_w)
   );

   tlb_rand_rem #(
      .DVD_W      (KEY_W),
      .DVS_W      (CNT_W),
      .SEQUENTIAL (SEQ_REM)
   ) u_rem (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (rem_start),
      .dividend_i (seed_w[GEN_W-1:GEN_DROP]),
      .divisor_i  (span_q),
      .done_o     (rem_done),
      .rem_o      (rem_w)
   );

   always_comb begin
      state_d   = state_q;
      lcg_step  = 1'b0;
      rem_start = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (req_i && !single_w) begin
               lcg_step = 1'b1;
               state_d  = ST_LOAD;
            end
         end
         ST_LOAD: begin
            rem_start = 1'b1;
            state_d   = ST_WAIT;
         end
         ST_WAIT: begin
            if (rem_done) begin
               if (cand_w == last_q) begin
                  lcg_step = 1'b1;
                  state_d  = ST_LOAD;
               end else begin
                  state_d  = ST_IDLE;
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         wir_q   <= '0;
         span_q  <= '0;
         last_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         state_q <= state_d;
         valid_q <= 1'b0;
         if (!busy_w && req_i) begin
            wir_q  <= wired_i;
            span_q <= entries_i - wired_i;
            if (single_w) begin
               last_q  <= IDX_W'(entries_i - CNT_W'(1));
               valid_q <= 1'b1;
            end
         end
         if (state_q == ST_WAIT && rem_done && cand_w != last_q) begin
            last_q  <= cand_w;
            valid_q <= 1'b1;
         end
      end
   end

   assign index_o = last_q;
   assign valid_o = valid_q;

endmodule

// File: rtl/tlb_rand_index_chk.sv
module tlb_rand_index_chk #(
   parameter int unsigned IDX_W = 6,
   parameter int unsigned CNT_W = 7,
   parameter int unsigned GEN_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             req_i,
   input  logic [CNT_W-1:0] entries_i,
   input  logic [CNT_W-1:0] wired_i,
   input  logic [IDX_W-1:0] index_o,
   input  logic             valid_o,
   input  logic             busy_w,
   input  logic [GEN_W-1:0] seed_w,
   input  logic [CNT_W-1:0] wir_q,
   input  logic [CNT_W-1:0] span_q
);

   logic             accept_w;
   logic             multi_w;
   logic             chk_multi_q;
   logic [IDX_W-1:0] chk_last_q;

   assign accept_w = req_i && !busy_w;
   assign multi_w  = ({1'b0, wired_i} + (CNT_W+1)'(1)) < {1'b0, entries_i};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chk_multi_q <= 1'b0;
         chk_last_q  <= '0;
      end else begin
         if (accept_w) chk_multi_q <= multi_w;
         if (valid_o)  chk_last_q  <= index_o;
      end
   end

   // R3: a multi-entry result stays inside the captured window
   a_r3_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && chk_multi_q) |->
         (CNT_W'(index_o) >= wir_q && CNT_W'(index_o) < (wir_q + span_q)));

   // R4: a multi-entry result differs from the index issued before it
   a_r4_no_repeat: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && chk_multi_q) |-> (index_o != chk_last_q));

   // R5: a one-slot window answers on the next cycle with the top slot
   a_r5_single_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept_w && !multi_w) |=>
         (valid_o && index_o == IDX_W'($past(entries_i) - CNT_W'(1))));

   // R5: the one-slot path leaves the generator untouched
   a_r5_seed_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept_w && !multi_w) |=> $stable(seed_w));

   // R7: index holds whenever no new result is flagged
   a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_o |-> $stable(index_o));

   // R9: the captured window does not move while busy
   a_r9_window_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_w |=> ($stable(wir_q) && $stable(span_q)));

endmodule

bind tlb_rand_index tlb_rand_index_chk #(
   .IDX_W (IDX_W),
   .CNT_W (CNT_W),
   .GEN_W (tlb_rand_pkg::GEN_W)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .req_i     (req_i),
   .entries_i (entries_i),
   .wired_i   (wired_i),
   .index_o   (index_o),
   .valid_o   (valid_o),
   .busy_w    (busy_w),
   .seed_w    (seed_w),
   .wir_q     (wir_q),
   .span_q    (span_q)
);

// File: tb/test_tlb_rand_index.sv
module test_tlb_rand_index;

   localparam int MAXE = 64;
   localparam int IW   = 6;
   localparam int CW   = 7;

   logic          clk   = 1'b0;
   logic          rst_n = 1'b0;
   logic          req   = 1'b0;
   logic [CW-1:0] ent   = '0;
   logic [CW-1:0] wir   = '0;
   logic [IW-1:0] idx_s, idx_c;
   logic          vld_s, vld_c;

   always #5 clk = ~clk;

   tlb_rand_index #(.MAX_ENTRIES(MAXE), .SEQ_REM(1'b1)) i_tlb_rand_index (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .entries_i(ent),
      .wired_i(wir), .index_o(idx_s), .valid_o(vld_s));

   tlb_rand_index #(.MAX_ENTRIES(MAXE), .SEQ_REM(1'b0)) i_tlb_rand_index_c (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .entries_i(ent),
      .wired_i(wir), .index_o(idx_c), .valid_o(vld_c));

   int          n_chk = 0;
   int          n_fail = 0;
   int          sent = 0;
   int          got_s = 0;
   int          got_c = 0;
   int unsigned m_seed = 1;
   int          m_prev = 0;
   int          exp_s[$];
   int          exp_c[$];
   int          last_s = 0;
   int          last_c = 0;
   int          cyc = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // reference model written from R2..R6
   function automatic int model_next(input int e, input int w);
      int r;
      int unsigned n;
      if (w + 1 >= e) begin
         r = (e - 1) & ((1 << IW) - 1);
      end else begin
         n = int'(e - w);
         do begin
            m_seed = m_seed * 32'd1103515245 + 32'd12345;
            r = int'((m_seed >> 16) % n) + w;
         end while (r == m_prev);
      end
      m_prev = r;
      return r;
   endfunction

   task automatic wait_done();
      while (got_s < sent || got_c < sent) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic issue(input int e, input int w);
      int r;
      r = model_next(e, w);
      exp_s.push_back(r);
      exp_c.push_back(r);
      sent++;
      @(negedge clk);
      ent = CW'(e);
      wir = CW'(w);
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      #1;
      wait_done();
   endtask

   // R5: one-slot window, result visible one cycle after the accepting edge
   task automatic issue_single_timed(input int e, input int w);
      int r;
      r = model_next(e, w);
      exp_s.push_back(r);
      exp_c.push_back(r);
      sent++;
      @(negedge clk);
      ent = CW'(e);
      wir = CW'(w);
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      check(vld_s === 1'b1 && idx_s == IW'(r), "R5 seq latency", int'(idx_s), r);
      check(vld_c === 1'b1 && idx_c == IW'(r), "R5 comb latency", int'(idx_c), r);
      #1;
      wait_done();
   endtask

   // R8 R9: second strobe while busy, with altered window inputs
   task automatic issue_busy(input int e, input int w, input int e2, input int w2);
      int r;
      r = model_next(e, w);
      exp_s.push_back(r);
      exp_c.push_back(r);
      sent++;
      @(negedge clk);
      ent = CW'(e);
      wir = CW'(w);
      req = 1'b1;
      @(negedge clk);
      ent = CW'(e2);
      wir = CW'(w2);
      @(negedge clk);
      req = 1'b0;
      #1;
      wait_done();
      repeat (30) @(negedge clk);
      check(got_s == sent, "R8 seq no extra result", got_s, sent);
      check(got_c == sent, "R8 comb no extra result", got_c, sent);
   endtask

   // scoreboard monitor: R3 R4 R6 R7 R10
   always @(negedge clk) begin
      int e;
      if (rst_n) begin
         if (vld_s) begin
            got_s++;
            if (exp_s.size() == 0) begin
               check(1'b0, "R8 seq unexpected valid", int'(idx_s), -1);
            end else begin
               e = exp_s.pop_front();
               check(idx_s == IW'(e), "R3 R4 R6 seq index", int'(idx_s), e);
            end
            last_s = int'(idx_s);
         end else begin
            check(int'(idx_s) == last_s, "R7 seq hold", int'(idx_s), last_s);
         end
         if (vld_c) begin
            got_c++;
            if (exp_c.size() == 0) begin
               check(1'b0, "R10 comb unexpected valid", int'(idx_c), -1);
            end else begin
               e = exp_c.pop_front();
               check(idx_c == IW'(e), "R10 comb index", int'(idx_c), e);
            end
            last_c = int'(idx_c);
         end else begin
            check(int'(idx_c) == last_c, "R7 comb hold", int'(idx_c), last_c);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         report();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(vld_s == 1'b0 && idx_s == '0, "R1 seq reset", int'(idx_s), 0);
      check(vld_c == 1'b0 && idx_c == '0, "R1 comb reset", int'(idx_c), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(vld_s == 1'b0 && vld_c == 1'b0, "R1 idle after reset", int'(vld_s), 0);

      // R2 R3: full-width window from seed 1
      for (int i = 0; i < 30; i++) issue(64, 0);
      // R3: offset window
      for (int i = 0; i < 25; i++) issue(16, 4);
      // R4: two-entry windows force retries
      for (int i = 0; i < 25; i++) issue(2, 0);
      for (int i = 0; i < 20; i++) issue(8, 6);
      for (int i = 0; i < 15; i++) issue(3, 1);
      // R5 R6: one-slot window, repeated, then a draw that must avoid it
      issue_single_timed(5, 4);
      issue_single_timed(5, 4);
      for (int i = 0; i < 5; i++) issue(5, 3);
      // R5: wired equal to entries, and top slot of a full table
      issue_single_timed(8, 8);
      issue_single_timed(64, 63);
      for (int i = 0; i < 5; i++) issue(64, 62);
      // R8 R9: strobes and input changes during a computation
      issue_busy(32, 2, 4, 3);
      issue_busy(12, 10, 40, 0);
      for (int i = 0; i < 10; i++) issue(40, 8);

      repeat (5) @(negedge clk);
      check(exp_s.size() == 0, "R10 seq queue drained", exp_s.size(), 0);
      check(exp_c.size() == 0, "R10 comb queue drained", exp_c.size(), 0);
      report();
   end

endmodule